// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block arbitrates eight interrupt requests for a small 8-bit microcontroller core. Four requests come from external active-low pins and four come from on-chip peripherals: two timers, a serial port and a third timer. The block holds the enable, priority and trigger-type settings and the pending flags for the external pins. It picks one winning request and presents it to the CPU as a registered request strobe and an 8-bit vector address.

Eight fixed slots set the polling order from highest to lowest: external 0, timer 0, external 1, timer 1, serial port, timer 2, external 2, external 3. Internal requests are levels that the peripheral holds until its own flag is cleared. Each external pin can detect a falling edge, which is latched in a flag, or a low level, which is followed directly. The controller keeps one in-service marker for each of the two priority levels, so a high-priority request can nest over a low-priority handler. The CPU confirms the vector with an acknowledge pulse and ends a handler with a return pulse.

Software reaches the settings through a byte-wide register port with four addresses. Address 0 (enable) and address 1 (priority) each hold one bit per slot, bit i for slot i. Address 2 holds the global enable in bit 7, the flags of external 1 and external 0 in bits 5 and 4, and the trigger types of external 1 and external 0 in bits 1 and 0. Address 3 is a combined control byte for externals 2 and 3.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Slot i has vector 8'h03 + 8*i. Among eligible requests at the same priority level, the lowest slot index wins (slots: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 ext2, 7 ext3).
- R2: A request from a slot whose enable bit (address 0, bit = slot index) is clear is never presented.
- R3: While the global enable (address 2 bit 7) is clear, irq_req stays low.
- R4: An eligible slot whose priority bit (address 1, bit = slot index) is set wins over any low-priority slot, whatever their polling order.
- R5: An acknowledged request marks its level in service. While the high level is in service, no request is presented. While only the low level is in service, only high-priority requests are presented. irq_ret clears the high marker if it is set, and otherwise clears the low marker.
- R6: With trigger type 1 (edge), a 1-then-0 pair of successive pin samples sets the pin's flag. The flag is cleared by hardware when that slot's vector is acknowledged, and a pin that stays low does not set it again.
- R7: With trigger type 0 (level), the request follows the sampled low level of the pin. A low pulse that ends while the slot is disabled leaves no request behind.
- R8: Address 3 reads and writes, from bit 7 down to bit 0: priority ext3, enable ext3, flag ext3, type ext3, priority ext2, enable ext2, flag ext2, type ext2. Its priority and enable bits are the same storage as bits 7 and 6 of addresses 1 and 0. All registers read 0 after reset.
- R9: irq_req and irq_vec are registered and read 0 after reset. A winner is taken when irq_ack is high while irq_req is high, and irq_req is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_n | input | 4 | External interrupt pins 0..3, active low |
| int_irq | input | 4 | Internal requests: timer0, timer1, serial, timer2 |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_ret | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the presented request |

## Verification
All four internal requests are raised together and served one by one. This tells correct polling order apart from an order that is reversed or shuffled. Two requests of opposite priority are then raised with the low one earlier in polling order, which separates priority from polling. A nested sequence follows: a low handler is entered, a high request preempts it, another high request waits, and the return pulses are issued. This shows which in-service marker each return clears. On the external pins, edge mode is distinguished from level mode by holding the pin low across an acknowledge and a return, and by giving a low pulse while the slot is disabled.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC      = 8;
  localparam int NEXT      = 4;
  localparam int IDXW      = $clog2(NSRC);
  localparam int VECW      = 8;
  localparam int VEC_SHIFT = 3;
  localparam logic [VECW-1:0] VEC_BASE = 8'h03;
  localparam int REGW      = 8;
  localparam int ADRW      = 2;

  localparam logic [ADRW-1:0] A_ENABLE = 2'd0;
  localparam logic [ADRW-1:0] A_PRIO   = 2'd1;
  localparam logic [ADRW-1:0] A_CFG    = 2'd2;
  localparam logic [ADRW-1:0] A_EXT23  = 2'd3;

  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VEC_BASE + (VECW'(idx) << VEC_SHIFT);
  endfunction

  // polling slot of external pin k
  function automatic logic [IDXW-1:0] ext_slot(input int k);
    case (k)
      0:       return IDXW'(0);
      1:       return IDXW'(2);
      2:       return IDXW'(6);
      default: return IDXW'(7);
    endcase
  endfunction

  // polling slot of internal request k (timer0, timer1, serial, timer2)
  function automatic logic [IDXW-1:0] int_slot(input int k);
    case (k)
      0:       return IDXW'(1);
      1:       return IDXW'(3);
      2:       return IDXW'(4);
      default: return IDXW'(5);
    endcase
  endfunction

  function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic flag_we,
  input  logic flag_wval,
  input  logic svc_clr,
  output logic flag_q,
  output logic low_lvl,
  output logic fell
);
  logic smp_now, smp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now  <= 1'b1;
      smp_prev <= 1'b1;
    end else begin
      smp_now  <= pin_n;
      smp_prev <= smp_now;
    end
  end

  assign fell    = smp_prev & ~smp_now;
  assign low_lvl = ~smp_now;

  logic flag_d;
  always_comb begin
    flag_d = flag_q;
    if (flag_we)                flag_d = flag_wval;
    if (svc_clr && edge_mode)   flag_d = 1'b0;
    if (fell && edge_mode)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && edge_mode) |=> flag_q); // R6
  AST_SERVICE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_clr && edge_mode && !fell && !flag_we) |=> !flag_q); // R6
  AST_LEVEL_NEVER_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !flag_we && !flag_q) |=> !flag_q); // R7
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADRW-1:0] addr,
  input  logic            we,
  input  logic [REGW-1:0] wdata,
  input  logic [NEXT-1:0] flags,
  output logic [REGW-1:0] rdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pri_q,
  output logic [NEXT-1:0] typ_q,
  output logic            gen_q,
  output logic [NEXT-1:0] flag_we,
  output logic [NEXT-1:0] flag_wval
);
  logic wr_en, wr_pri, wr_cfg, wr_x23;
  assign wr_en  = we && (addr == A_ENABLE);
  assign wr_pri = we && (addr == A_PRIO);
  assign wr_cfg = we && (addr == A_CFG);
  assign wr_x23 = we && (addr == A_EXT23);

  assign flag_we   = {wr_x23, wr_x23, wr_cfg, wr_cfg};
  assign flag_wval = {wdata[5], wdata[1], wdata[5], wdata[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
      typ_q <= '0;
      gen_q <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= wdata;
      if (wr_pri) pri_q <= wdata;
      if (wr_cfg) begin
        gen_q      <= wdata[7];
        typ_q[1:0] <= wdata[1:0];
      end
      if (wr_x23) begin
        pri_q[7] <= wdata[7];
        en_q[7]  <= wdata[6];
        typ_q[3] <= wdata[4];
        pri_q[6] <= wdata[3];
        en_q[6]  <= wdata[2];
        typ_q[2] <= wdata[0];
      end
    end
  end

  always_comb begin
    case (addr)
      A_ENABLE: rdata = en_q;
      A_PRIO:   rdata = pri_q;
      A_CFG:    rdata = {gen_q, 1'b0, flags[1], flags[0], 2'b00, typ_q[1], typ_q[0]};
      default:  rdata = {pri_q[7], en_q[7], flags[3], typ_q[3],
                         pri_q[6], en_q[6], flags[2], typ_q[2]};
    endcase
  end

  AST_X23_ALIASES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x23 |=> (en_q[7:6] == {$past(wdata[6]), $past(wdata[2])})); // R8
  AST_X23_ALIASES_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x23 |=> (pri_q[7:6] == {$past(wdata[7]), $past(wdata[3])})); // R8
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_fire,
  input  logic ack_hi,
  input  logic ret,
  output logic ins_hi,
  output logic ins_lo
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = ins_hi;
    lo_d = ins_lo;
    if (ret) begin
      if (ins_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (ack_fire) begin
      if (ack_hi) hi_d = 1'b1;
      else        lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_d;
      ins_lo <= lo_d;
    end
  end

  AST_LOW_NOT_ENTERED_UNDER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_lo) |-> $past(!ins_hi)); // R5
  AST_RETURN_CLEARS_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ins_hi && !ack_fire) |=> (!ins_hi && (ins_lo == $past(ins_lo)))); // R5
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] pri,
  input  logic            gen,
  input  logic            ins_hi,
  input  logic            ins_lo,
  input  logic            ack,
  output logic            ack_fire,
  output logic            req_q,
  output logic [VECW-1:0] vec_q,
  output logic [IDXW-1:0] sel_idx_q,
  output logic            sel_hi_q
);
  logic [NSRC-1:0] elig, hi_set, lo_set;
  logic            hi_ok, lo_ok, win_valid;
  logic [IDXW-1:0] win_idx;

  assign elig      = pend & en & {NSRC{gen}};
  assign hi_set    = elig & pri;
  assign lo_set    = elig & ~pri;
  assign hi_ok     = (|hi_set) && !ins_hi;
  assign lo_ok     = (|lo_set) && !ins_hi && !ins_lo;
  assign win_valid = hi_ok || lo_ok;
  assign win_idx   = hi_ok ? first_set(hi_set) : first_set(lo_set);
  assign ack_fire  = ack && req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      sel_idx_q <= '0;
      sel_hi_q  <= 1'b0;
    end else begin
      req_q     <= win_valid && !ack_fire;
      vec_q     <= (win_valid && !ack_fire) ? vec_of(win_idx) : '0;
      sel_idx_q <= win_idx;
      sel_hi_q  <= hi_ok;
    end
  end

  AST_VECTOR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (vec_q[VEC_SHIFT-1:0] == VEC_BASE[VEC_SHIFT-1:0])); // R1
  AST_POLL_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !hi_ok) |-> ((lo_set & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0)); // R1
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (en[win_idx] && pend[win_idx])); // R2
  AST_REQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(gen)); // R3
  AST_HIGH_BEATS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hi_set) && !ins_hi) |-> pri[win_idx]); // R4
  AST_HIGH_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !win_valid); // R5
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !req_q); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_irq_n,
  input  logic [3:0]      int_irq,
  input  logic [ADRW-1:0] reg_addr,
  input  logic            reg_we,
  input  logic [REGW-1:0] reg_wdata,
  output logic [REGW-1:0] reg_rdata,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_req,
  output logic [VECW-1:0] irq_vec
);
  logic [NSRC-1:0] en_q, pri_q, pend;
  logic [NEXT-1:0] typ_q, flags, lows, falls, flag_we, flag_wval;
  logic            gen_q, ack_fire, sel_hi_q, ins_hi, ins_lo;
  logic [IDXW-1:0] sel_idx_q;

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .flags(flags), .rdata(reg_rdata), .en_q(en_q), .pri_q(pri_q), .typ_q(typ_q),
    .gen_q(gen_q), .flag_we(flag_we), .flag_wval(flag_wval)
  );

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    localparam logic [IDXW-1:0] SLOT = ext_slot(k);
    logic svc_clr;
    assign svc_clr = ack_fire && (sel_idx_q == SLOT);
    irq_pin_detect u_pin (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_irq_n[k]), .edge_mode(typ_q[k]),
      .flag_we(flag_we[k]), .flag_wval(flag_wval[k]), .svc_clr(svc_clr),
      .flag_q(flags[k]), .low_lvl(lows[k]), .fell(falls[k])
    );
    assign pend[SLOT] = typ_q[k] ? flags[k] : lows[k];
  end

  for (genvar k = 0; k < 4; k++) begin : g_int
    localparam logic [IDXW-1:0] SLOT = int_slot(k);
    assign pend[SLOT] = int_irq[k];
  end

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en_q), .pri(pri_q), .gen(gen_q),
    .ins_hi(ins_hi), .ins_lo(ins_lo), .ack(irq_ack), .ack_fire(ack_fire),
    .req_q(irq_req), .vec_q(irq_vec), .sel_idx_q(sel_idx_q), .sel_hi_q(sel_hi_q)
  );

  irq_inservice u_ins (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_hi(sel_hi_q),
    .ret(irq_ret), .ins_hi(ins_hi), .ins_lo(ins_lo)
  );

  AST_EDGE_FLAG_NOT_ON_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (typ_q[2] && !falls[2] && !flag_we[2] && !flags[2]) |=> !flags[2]); // R6
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_irq_n = 4'hF;
  logic [3:0] int_irq = 4'h0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expq[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_irq(int_irq),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // vector expected for a slot, restated from R1
  function automatic logic [7:0] slot_vec(input int s);
    return 8'(3 + s * 8);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected vector per handshake
  always @(negedge clk) begin
    if (rst_n && irq_req && irq_ack) begin
      if (expq.size() == 0) chk("R1 unexpected handshake", irq_vec, 8'hFF);
      else                  chk("R1 vector", irq_vec, expq.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic take(input logic [7:0] exp);
    bit got = 1'b0;
    expq.push_back(exp);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq_req) begin got = 1'b1; break; end
    end
    if (!got) begin
      void'(expq.pop_back());
      chk("R9 request never raised", 8'h00, exp);
    end else begin
      @(posedge clk); #1; irq_ack = 1'b1;
      @(posedge clk); #1; irq_ack = 1'b0;
      @(negedge clk);
      chk("R9 request dropped after ack", {7'b0, irq_req}, 8'h00);
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (irq_req) seen = 1'b1;
    end
    chk(tag, {7'b0, seen}, 8'h00);
  endtask

  task automatic ret_pulse();
    @(posedge clk); #1; irq_ret = 1'b1;
    @(posedge clk); #1; irq_ret = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset req", {7'b0, irq_req}, 8'h00);
    chk("R9 reset vec", irq_vec, 8'h00);
    for (int a = 0; a < 4; a++) rdchk(2'(a), 8'h00, "R8 reset register");

    // R8: combined ext2/ext3 byte and aliasing
    wr(2'd3, 8'hC5);
    rdchk(2'd0, 8'hC0, "R8 enable alias");
    rdchk(2'd1, 8'h80, "R8 priority alias");
    rdchk(2'd2, 8'h00, "R8 cfg untouched");
    rdchk(2'd3, 8'hC5, "R8 readback");
    wr(2'd3, 8'h00);

    // R3: global enable gates ext0 level request
    wr(2'd0, 8'h01);
    ext_irq_n[0] = 1'b0;
    quiet(12, "R3 global off");
    wr(2'd2, 8'h80);
    take(slot_vec(0));
    quiet(8, "R5 same level blocked");
    ret_pulse();
    take(slot_vec(0));          // R7 level still low: presented again
    ext_irq_n[0] = 1'b1;
    ret_pulse();
    quiet(8, "R7 released level gone");

    // R2: disabled slot ignored
    wr(2'd0, 8'h00);
    int_irq[1] = 1'b1;
    quiet(12, "R2 disabled timer1");
    int_irq = 4'h0;

    // R1: polling order over internal slots
    wr(2'd0, 8'h3A);
    int_irq = 4'hF;
    for (int k = 0; k < 4; k++) begin
      int s;
      s = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 4 : 5;
      take(slot_vec(s));
      int_irq[k] = 1'b0;
      ret_pulse();
    end
    quiet(8, "R1 all served");

    // R4: high serial beats low timer0
    wr(2'd1, 8'h10);
    int_irq = 4'b0101;
    take(slot_vec(4));
    int_irq[2] = 1'b0;
    ret_pulse();
    take(slot_vec(1));
    int_irq[0] = 1'b0;
    ret_pulse();

    // R5: nesting
    int_irq[0] = 1'b1;
    take(slot_vec(1));
    int_irq[2] = 1'b1;
    take(slot_vec(4));
    wr(2'd1, 8'h30);
    int_irq[3] = 1'b1;
    quiet(10, "R5 no preempt at same level");
    int_irq[2] = 1'b0;
    int_irq[0] = 1'b0;
    ret_pulse();
    take(slot_vec(5));
    int_irq[3] = 1'b0;
    ret_pulse();
    ret_pulse();
    int_irq[0] = 1'b1;
    take(slot_vec(1));          // R5 low marker was cleared by second return
    int_irq[0] = 1'b0;
    ret_pulse();
    wr(2'd1, 8'h00);

    // R6: edge mode on ext2
    wr(2'd3, 8'h05);
    ext_irq_n[2] = 1'b0;
    repeat (4) @(posedge clk);
    rdchk(2'd3, 8'h07, "R6 flag set by edge");
    take(slot_vec(6));
    rdchk(2'd3, 8'h05, "R6 flag cleared on ack");
    ret_pulse();
    quiet(10, "R6 steady low no new edge");
    ext_irq_n[2] = 1'b1;

    // R7: level pulse while disabled is not latched
    wr(2'd3, 8'h00);
    ext_irq_n[3] = 1'b0;
    repeat (3) @(posedge clk);
    #1 ext_irq_n[3] = 1'b1;
    wr(2'd3, 8'h40);
    quiet(10, "R7 level not latched");
    ext_irq_n[3] = 1'b0;
    take(slot_vec(7));
    ext_irq_n[3] = 1'b1;
    ret_pulse();

    // R1/R6: ext1 in edge mode
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h82);
    ext_irq_n[1] = 1'b0;
    take(slot_vec(2));
    ret_pulse();
    ext_irq_n[1] = 1'b1;
    quiet(8, "R6 ext1 single edge");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule